// File: doc/BRIEF.md
# I2C Master Receive Sequencer

This block runs the receive phase of an I2C bus master once the slave has been addressed. Each transfer starts when software reads the received-data port. The block then releases SCL and clocks in a programmable number of bits. If enabled, it adds one more clock in which it pulls SDA low as the acknowledge. When the transfer ends it raises a one-cycle interrupt, clears the pending flag and holds SCL low until software reads again. The word returned by the first read after addressing has no meaning; that read only starts the first transfer.

A read ends in two steps. Software first clears the acknowledge enable before it reads the second-to-last word, so the last word is clocked without an acknowledge pulse. After that word's interrupt, software selects a one-bit length and reads again. The block then gives one clock with SDA left high, which the slave takes as a not-acknowledge. After that clock it asks an external stop generator for a stop condition. SCL and SDA are modelled as separate active-high pull-low drives and sensed line levels.

Top module: `i2c_mrx_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pending` is 1, `irq` and `stop_req` are 0, and neither `scl_drive_low` nor `sda_drive_low` is asserted. The length code resets to 000 and the acknowledge enable resets to 1.
- R2: A length code of 000 clocks 8 data bits. A code n from 1 to 7 clocks n data bits, and those bits land in `rd_data[n-1:0]`.
- R3: A one-cycle `rd_strobe`, given while no transfer is running, sets `pending` to 1 on the next cycle and starts a transfer.
- R4: When the last clock of a transfer ends, `irq` pulses for one cycle and `pending` goes to 0. From then on `scl_drive_low` stays asserted until the next `rd_strobe`.
- R5: Data bits are taken MSB first. The first sampled bit becomes the most significant bit of the received word, and the word is on `rd_data` by the time `irq` pulses.
- R6: With the acknowledge enable set, one extra clock follows the data bits and `sda_drive_low` is asserted during it. With the enable clear, no extra clock is given.
- R7: `sda_drive_low` changes only while the block is driving SCL low. SDA is sampled when the sensed `scl_in` first reads high in a high phase.
- R8: The high phase is counted only while `scl_in` reads high. A slave that holds SCL low stalls the block, and after `scl_in` rises the block releases SCL for `half_period` cycles.
- R9: A one-bit transfer with the acknowledge enable clear leaves SDA released during its clock. `stop_req` then pulses for one cycle, the cycle after that transfer's `irq`. `stop_req` is never raised after any other transfer.
- R10: A one-cycle `cfg_we` loads `cfg_bits` and `cfg_ack` as the length code and acknowledge enable used by the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | DIV_W | SCL low and high phase length in clock cycles (0 counts as 1) |
| cfg_we | input | 1 | Write strobe for the length code and acknowledge enable |
| cfg_bits | input | 3 | Length code (000 means 8 bits) |
| cfg_ack | input | 1 | Acknowledge enable |
| rd_strobe | input | 1 | Software read of the received-data register |
| rd_data | output | 8 | Received-data register |
| pending | output | 1 | 1 while a transfer is requested or running, 0 while waiting for a read |
| irq | output | 1 | One-cycle end-of-transfer interrupt |
| stop_req | output | 1 | One-cycle request to the stop-condition generator |
| scl_drive_low | output | 1 | Pull SCL low |
| scl_in | input | 1 | Sensed SCL level |
| sda_drive_low | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
A wrong bit index or plan shows up at the end of the transfer it belongs to. Either the number of SCL rises before `irq` is off, or the acknowledge clock shows the wrong SDA level. A fault in the shift path shows up as a wrong `rd_data` when `irq` pulses. A wrong phase state shows up within one phase: SCL is released while it should be held, SDA changes while SCL is high, or `stop_req` is raised at the wrong time. A timer that ignores `scl_in` shows up as a high phase of the wrong length after a stretch is let go.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;

    localparam int WORD_W = 8;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_LOW,
        ST_HIGH,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [2:0] len_code;
        logic       ack_en;
    } rx_cfg_t;

    typedef struct packed {
        logic [IDX_W-1:0] total;
        logic [IDX_W-1:0] data_bits;
        logic             ack_clk;
        logic             nack_end;
    } rx_plan_t;

    function automatic logic [IDX_W-1:0] data_len(input logic [2:0] code);
        return (code == 3'b000) ? IDX_W'(WORD_W) : IDX_W'(code);
    endfunction

    function automatic rx_plan_t make_plan(input rx_cfg_t c);
        rx_plan_t p;
        p.data_bits = data_len(c.len_code);
        p.ack_clk   = c.ack_en;
        p.total     = p.data_bits + IDX_W'(c.ack_en);
        p.nack_end  = (c.len_code == 3'b001) && !c.ack_en;
        return p;
    endfunction

endpackage

// File: rtl/rx_phase_timer.sv
module rx_phase_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         first,
    output logic         done
);
    logic [W-1:0] cnt;
    logic [W-1:0] eff;

    assign eff   = (limit == '0) ? W'(1) : limit;
    assign first = run && (cnt == '0);
    assign done  = run && (cnt >= eff - W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         capture,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            word <= '0;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], bit_in};
            if (capture) begin
                word <= {sreg[W-2:0], bit_in};
            end
        end
    end
endmodule

// File: rtl/i2c_mrx_seq.sv
module i2c_mrx_seq
    import i2c_mrx_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  half_period,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_bits,
    input  logic              cfg_ack,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    output logic              pending,
    output logic              irq,
    output logic              stop_req,
    output logic              scl_drive_low,
    input  logic              scl_in,
    output logic              sda_drive_low,
    input  logic              sda_in
);
    rx_state_e        state;
    rx_cfg_t          cfg;
    rx_plan_t         plan;
    logic [IDX_W-1:0] bit_idx;
    logic             tmr_run, tmr_clear, tmr_first, tmr_done;
    logic             in_phase, is_data_bit, last_clk, sample, capture;

    assign in_phase      = (state == ST_LOW) || (state == ST_HIGH);
    assign tmr_run       = (state == ST_LOW) || ((state == ST_HIGH) && scl_in);
    assign tmr_clear     = tmr_done || !in_phase;
    assign is_data_bit   = bit_idx < plan.data_bits;
    assign last_clk      = bit_idx == plan.total - IDX_W'(1);
    assign sample        = (state == ST_HIGH) && tmr_first && is_data_bit;
    assign capture       = bit_idx == plan.data_bits - IDX_W'(1);
    assign scl_drive_low = (state == ST_LOW) || (state == ST_HOLD) || (state == ST_STOP);

    rx_phase_timer #(.W(DIV_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clear),
        .run   (tmr_run),
        .limit (half_period),
        .first (tmr_first),
        .done  (tmr_done)
    );

    rx_shifter #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .shift   (sample),
        .capture (capture),
        .bit_in  (sda_in),
        .word    (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cfg           <= '{len_code: 3'b000, ack_en: 1'b1};
            plan          <= '0;
            bit_idx       <= '0;
            pending       <= 1'b1;
            irq           <= 1'b0;
            stop_req      <= 1'b0;
            sda_drive_low <= 1'b0;
        end else begin
            irq      <= 1'b0;
            stop_req <= 1'b0;
            if (cfg_we) begin
                cfg <= '{len_code: cfg_bits, ack_en: cfg_ack};
            end
            unique case (state)
                ST_IDLE, ST_HOLD, ST_STOP: begin
                    if (state == ST_STOP) begin
                        stop_req <= 1'b1;
                        state    <= ST_HOLD;
                    end
                    if (rd_strobe) begin
                        plan    <= make_plan(cfg);
                        bit_idx <= '0;
                        pending <= 1'b1;
                        state   <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    // SDA is updated only inside the low phase
                    if (tmr_first) begin
                        sda_drive_low <= plan.ack_clk && (bit_idx == plan.data_bits);
                    end
                    if (tmr_done) begin
                        state <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tmr_done) begin
                        if (last_clk) begin
                            irq     <= 1'b1;
                            pending <= 1'b0;
                            state   <= plan.nack_end ? ST_STOP : ST_HOLD;
                        end else begin
                            bit_idx <= bit_idx + IDX_W'(1);
                            state   <= ST_LOW;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_mrx_seq_chk.sv
module i2c_mrx_seq_chk (
    input logic clk,
    input logic rst,
    input logic rd_strobe,
    input logic pending,
    input logic irq,
    input logic stop_req,
    input logic scl_drive_low,
    input logic sda_drive_low
);
    AST_READ_SETS_PENDING: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && !pending |=> pending); // R3

    AST_IRQ_CLEARS_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq |-> !pending); // R4

    AST_HOLD_AT_IRQ: assert property (@(posedge clk) disable iff (rst)
        irq |-> scl_drive_low); // R4

    AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
        !pending && !rd_strobe |=> scl_drive_low); // R4

    AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_drive_low) |-> $past(scl_drive_low)); // R7

    AST_STOP_FOLLOWS_IRQ: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> $past(irq)); // R9

    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stop_req); // R9
endmodule

bind i2c_mrx_seq i2c_mrx_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_strobe     (rd_strobe),
    .pending       (pending),
    .irq           (irq),
    .stop_req      (stop_req),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low)
);

// File: tb/i2c_mrx_seq_tb.sv
module i2c_mrx_seq_tb;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] half_period = 12'(HALF);
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_bits = 3'b000;
    logic        cfg_ack = 1'b1;
    logic        rd_strobe = 1'b0;
    logic [7:0]  rd_data;
    logic        pending, irq, stop_req, scl_drive_low, sda_drive_low;
    logic        scl_in, sda_in;
    logic        stretch = 1'b0;

    logic [7:0]  slave_byte = 8'h00;
    int          slave_idx = 8;
    int          rise_cnt = 0;
    logic [15:0] samp = '0;
    int          stop_cnt = 0;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    assign scl_in = !scl_drive_low && !stretch;
    assign sda_in = !(sda_drive_low ||
                      (slave_idx >= 0 && slave_idx < 8 && !slave_byte[7 - slave_idx]));

    i2c_mrx_seq u_dut (
        .clk(clk), .rst(rst), .half_period(half_period),
        .cfg_we(cfg_we), .cfg_bits(cfg_bits), .cfg_ack(cfg_ack),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .pending(pending),
        .irq(irq), .stop_req(stop_req), .scl_drive_low(scl_drive_low),
        .scl_in(scl_in), .sda_drive_low(sda_drive_low), .sda_in(sda_in)
    );

    // slave moves to its next bit each time the master pulls SCL low
    always @(posedge scl_drive_low) slave_idx = slave_idx + 1;

    // master release of SCL: record the SDA level seen at the rise
    always @(negedge scl_drive_low) begin
        if (rise_cnt < 16) samp[rise_cnt] = sda_in;
        rise_cnt = rise_cnt + 1;
    end

    always @(posedge clk) if (!rst && stop_req) stop_cnt <= stop_cnt + 1;

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic prep(input logic [7:0] b, input bit active);
        slave_byte = b;
        if (!active) slave_idx = 8;
        else slave_idx = scl_drive_low ? 0 : -1;
        rise_cnt = 0;
        samp = '0;
    endtask

    task automatic write_cfg(input logic [2:0] bits, input logic ack);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bits = bits; cfg_ack = ack;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (irq !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, irq, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 pending", pending, 1'b1);
        chk("R1 irq", irq, 1'b0);
        chk("R1 stop_req", stop_req, 1'b0);
        chk("R1 scl", scl_drive_low, 1'b0);
        chk("R1 sda", sda_drive_low, 1'b0);
    endtask

    task automatic t_first_word();
        prep(8'hA5, 1'b1);
        pulse_read();
        wait_irq("R4 irq first word");
        chk("R2 R6 clocks 8+ack", rise_cnt, 9);
        chk("R5 data A5", rd_data, 8'hA5);
        chk("R6 ack SDA low", samp[8], 1'b0);
        chk("R4 pending low at irq", pending, 1'b0);
        chk("R4 scl held at irq", scl_drive_low, 1'b1);
    endtask

    task automatic t_hold();
        repeat (50) @(negedge clk);
        chk("R4 scl still held", scl_drive_low, 1'b1);
        chk("R4 pending still low", pending, 1'b0);
        chk("R4 irq single pulse", irq, 1'b0);
    endtask

    task automatic t_next_word();
        prep(8'h3C, 1'b1);
        pulse_read();
        chk("R3 pending set by read", pending, 1'b1);
        wait_irq("R4 irq second word");
        chk("R5 data 3C", rd_data, 8'h3C);
        chk("R6 clocks with ack", rise_cnt, 9);
    endtask

    task automatic t_short();
        write_cfg(3'b011, 1'b0);
        prep(8'hB3, 1'b1);
        pulse_read();
        wait_irq("R2 irq short");
        chk("R10 R2 three clocks", rise_cnt, 3);
        chk("R2 R5 low bits 101", rd_data[2:0], 3'b101);
    endtask

    task automatic t_stretch();
        int n = 0;
        write_cfg(3'b000, 1'b1);
        prep(8'h96, 1'b1);
        pulse_read();
        while (scl_drive_low) @(negedge clk);
        stretch = 1'b1;
        repeat (20) @(negedge clk);
        chk("R8 stalled while stretched", scl_drive_low, 1'b0);
        stretch = 1'b0;
        @(negedge clk);
        while (!scl_drive_low && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R8 high phase after release", n, HALF - 1);
        wait_irq("R8 irq after stretch");
        chk("R7 R8 data 96", rd_data, 8'h96);
    endtask

    task automatic t_terminate();
        write_cfg(3'b000, 1'b0);
        prep(8'h5A, 1'b1);
        pulse_read();
        wait_irq("R6 irq last word");
        chk("R6 no ack clock", rise_cnt, 8);
        chk("R5 last word 5A", rd_data, 8'h5A);
        @(negedge clk);
        chk("R9 no stop after normal words", stop_cnt, 0);
        write_cfg(3'b001, 1'b0);
        prep(8'h00, 1'b0);
        pulse_read();
        wait_irq("R9 irq nack bit");
        chk("R9 one clock", rise_cnt, 1);
        chk("R9 SDA high at nack", samp[0], 1'b1);
        chk("R9 no stop with irq", stop_req, 1'b0);
        @(negedge clk);
        chk("R9 stop after irq", stop_req, 1'b1);
        @(negedge clk);
        chk("R9 stop one pulse", stop_cnt, 1);
        chk("R9 scl held after stop", scl_drive_low, 1'b1);
    endtask

    initial begin
        repeat (2000 * 50) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_word();
        t_hold();
        t_next_word();
        t_short();
        t_stretch();
        t_terminate();
        finish_run();
    end
endmodule